// File: doc/BRIEF.md
# Floating-Point Condition-Group Branch Evaluator

This block decodes coprocessor-1 conditional branches that test a small aligned group of floating-point condition codes instead of one code. A two-code form and a four-code form exist. Each names a starting index into the 8-bit condition-code vector and a sense bit. The branch is taken when at least one code in the group equals the sense bit. The block takes the fetched instruction word, the condition-code vector, the address of the next sequential instruction, a valid strobe and an FPU-enable input. One clock later it presents registered results: whether the word was such a branch, whether it is taken, whether its group index is misaligned (unpredictable), the branch target, and a delay-slot marker.

Every decoded branch owns one delay-slot instruction, so the pipeline fetches one more sequential word before any redirect. A second registered stage raises a redirect strobe, carrying the target, one cycle after a taken result. A misaligned group index never produces a taken result or a redirect.

Top module: `fpcc_group_branch`

## Requirements
- R1: `isBranch` is 1 one cycle after a cycle with `instrValid`=1, `fpuEnable`=1, instruction bits 31:26 = 6'b010001, bits 25:21 equal to 5'b01001 (two-code form) or 5'b01010 (four-code form), and bit 17 = 0. Otherwise it is 0.
- R2: For the two-code form with an aligned index (cc = bits 20:18, sense = bit 16), `taken` is 1 one cycle later exactly when condCodes[cc] or condCodes[cc+1] equals the sense.
- R3: For the four-code form with an aligned index, `taken` is 1 one cycle later exactly when any of condCodes[cc], condCodes[cc+1], condCodes[cc+2], condCodes[cc+3] equals the sense.
- R4: For a decoded two-code branch, `unpredictable` is 1 one cycle later exactly when cc bit 0 is 1.
- R5: For a decoded four-code branch, `unpredictable` is 1 one cycle later exactly when cc bits 1:0 are not both 0.
- R6: When `unpredictable` is 1, `taken` is 0 and no redirect follows.
- R7: With `instrValid`=0 or `fpuEnable`=0, `isBranch`, `taken`, `unpredictable` and `delaySlot` are 0 in the next cycle, whatever the instruction word holds.
- R8: For a decoded branch, `target` equals `nextPc` plus the 16-bit offset (bits 15:0), sign-extended and shifted left by 2, modulo 2^ADDR_W. For any other word it is 0.
- R9: `delaySlot` is 1 in the same cycle as `isBranch`, including for misaligned branches.
- R10: `redirectValid` is 1 exactly one cycle after `taken` was 1, with `redirectTarget` equal to the target shown with that taken result. Otherwise `redirectTarget` is 0.
- R11: A synchronous active-high `rst` clears every output at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instrValid | input | 1 | Instruction word is valid this cycle |
| fpuEnable | input | 1 | Floating-point unit usable |
| instrWord | input | 32 | Fetched instruction word |
| condCodes | input | 8 | Floating-point condition-code vector |
| nextPc | input | ADDR_W | Address of the next sequential instruction |
| isBranch | output | 1 | Registered: word was a group branch |
| taken | output | 1 | Registered: branch condition met |
| unpredictable | output | 1 | Registered: misaligned group index |
| target | output | ADDR_W | Registered branch target |
| delaySlot | output | 1 | Registered: one delay-slot fetch is due |
| redirectValid | output | 1 | Redirect after the delay slot |
| redirectTarget | output | ADDR_W | Address for the redirect |

## Verification
The bench builds the block with ADDR_W = 40. Addresses then run past 32 bits, so sign extension of negative offsets into the upper bits and wrap-around at 2^40 can both be observed on `target`. The random words mostly carry the right major opcode and one of the two group forms. This makes each aligned and misaligned index frequent in both forms, alongside words that only just miss the decode.

// File: rtl/fpcc_branch_pkg.sv
package fpcc_branch_pkg;

  localparam int INSTR_W  = 32;
  localparam int CC_IDX_W = 3;
  localparam int NUM_CC   = 1 << CC_IDX_W;
  localparam int OFF_W    = 16;

  localparam logic [5:0] OPC_COP1  = 6'b010001;
  localparam logic [4:0] FORM_PAIR = 5'b01001;
  localparam logic [4:0] FORM_QUAD = 5'b01010;

  // Strobes from the decoder to the evaluator
  typedef struct packed {
    logic                hit;
    logic                quad;
    logic                misaligned;
    logic                sense;
    logic [CC_IDX_W-1:0] ccBase;
  } brStrobe_t;

endpackage

// File: rtl/fpcc_branch_decode.sv
module fpcc_branch_decode
  import fpcc_branch_pkg::*;
(
  input  logic                  instrValid,
  input  logic                  fpuEnable,
  input  logic [INSTR_W-1:0]    instrWord,
  output brStrobe_t             strobe,
  output logic [OFF_W-1:0]      offset
);

  logic [5:0]          majorOp;
  logic [4:0]          formSel;
  logic [CC_IDX_W-1:0] ccIdx;
  logic                padBit;
  logic                isPair;
  logic                isQuad;
  logic                gateOk;

  always_comb begin
    majorOp = instrWord[31:26];
    formSel = instrWord[25:21];
    ccIdx   = instrWord[20:18];
    padBit  = instrWord[17];
    offset  = instrWord[OFF_W-1:0];
    gateOk  = instrValid && fpuEnable;
    isPair  = (formSel == FORM_PAIR);
    isQuad  = (formSel == FORM_QUAD);

    strobe.hit        = gateOk && (majorOp == OPC_COP1) && (isPair || isQuad) && !padBit;
    strobe.quad       = isQuad;
    strobe.sense      = instrWord[16];
    strobe.ccBase     = ccIdx;
    // Group must start on a multiple of its size
    strobe.misaligned = strobe.hit && (isQuad ? (ccIdx[1:0] != 2'b00) : ccIdx[0]);
  end

endmodule

// File: rtl/fpcc_branch_eval.sv
module fpcc_branch_eval
  import fpcc_branch_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  brStrobe_t          strobe,
  input  logic [OFF_W-1:0]   offset,
  input  logic [NUM_CC-1:0]  condCodes,
  input  logic [ADDR_W-1:0]  nextPc,
  output logic               isBranch,
  output logic               taken,
  output logic               unpredictable,
  output logic [ADDR_W-1:0]  target,
  output logic               delaySlot,
  output logic               redirectValid,
  output logic [ADDR_W-1:0]  redirectTarget
);

  localparam int MAX_GROUP = 4;
  localparam int EXT_W     = ADDR_W - OFF_W - 2;

  logic [MAX_GROUP-1:0] laneMatch;
  logic                 anyMatch;
  logic [ADDR_W-1:0]    byteOffset;
  logic [ADDR_W-1:0]    targetNext;

  for (genvar k = 0; k < MAX_GROUP; k++) begin : g_lane
    logic [CC_IDX_W-1:0] laneIdx;
    assign laneIdx      = strobe.ccBase + CC_IDX_W'(k);
    assign laneMatch[k] = (condCodes[laneIdx] == strobe.sense);
  end

  always_comb begin
    anyMatch   = laneMatch[0] || laneMatch[1] ||
                 (strobe.quad && (laneMatch[2] || laneMatch[3]));
    byteOffset = {{EXT_W{offset[OFF_W-1]}}, offset, 2'b00};
    targetNext = nextPc + byteOffset;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      isBranch       <= 1'b0;
      taken          <= 1'b0;
      unpredictable  <= 1'b0;
      target         <= '0;
      delaySlot      <= 1'b0;
      redirectValid  <= 1'b0;
      redirectTarget <= '0;
    end else begin
      isBranch       <= strobe.hit;
      taken          <= strobe.hit && !strobe.misaligned && anyMatch;
      unpredictable  <= strobe.misaligned;
      target         <= strobe.hit ? targetNext : '0;
      delaySlot      <= strobe.hit;
      redirectValid  <= taken;
      redirectTarget <= taken ? target : '0;
    end
  end

  p_taken_needs_branch_r2: assert property (@(posedge clk) disable iff (rst)
    taken |-> isBranch);

  p_unpred_blocks_taken_r6: assert property (@(posedge clk) disable iff (rst)
    unpredictable |-> !taken);

  p_unpred_no_redirect_r6: assert property (@(posedge clk) disable iff (rst)
    unpredictable |=> !redirectValid);

  p_slot_with_branch_r9: assert property (@(posedge clk) disable iff (rst)
    delaySlot == isBranch);

  p_redirect_carries_target_r10: assert property (@(posedge clk) disable iff (rst)
    taken |=> (redirectValid && redirectTarget == $past(target)));

endmodule

// File: rtl/fpcc_group_branch.sv
module fpcc_group_branch
  import fpcc_branch_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               instrValid,
  input  logic               fpuEnable,
  input  logic [31:0]        instrWord,
  input  logic [7:0]         condCodes,
  input  logic [ADDR_W-1:0]  nextPc,
  output logic               isBranch,
  output logic               taken,
  output logic               unpredictable,
  output logic [ADDR_W-1:0]  target,
  output logic               delaySlot,
  output logic               redirectValid,
  output logic [ADDR_W-1:0]  redirectTarget
);

  brStrobe_t        strobe;
  logic [OFF_W-1:0] offset;

  fpcc_branch_decode u_decode (
    .instrValid (instrValid),
    .fpuEnable  (fpuEnable),
    .instrWord  (instrWord),
    .strobe     (strobe),
    .offset     (offset)
  );

  fpcc_branch_eval #(.ADDR_W(ADDR_W)) u_eval (
    .clk            (clk),
    .rst            (rst),
    .strobe         (strobe),
    .offset         (offset),
    .condCodes      (condCodes),
    .nextPc         (nextPc),
    .isBranch       (isBranch),
    .taken          (taken),
    .unpredictable  (unpredictable),
    .target         (target),
    .delaySlot      (delaySlot),
    .redirectValid  (redirectValid),
    .redirectTarget (redirectTarget)
  );

  p_gate_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    (!instrValid || !fpuEnable) |=> (!isBranch && !taken && !unpredictable));

  p_pad_bit_rejects_r1: assert property (@(posedge clk) disable iff (rst)
    instrWord[17] |=> !isBranch);

  p_pair_misalign_r4: assert property (@(posedge clk) disable iff (rst)
    (instrWord[25:21] == 5'b01001 && !instrWord[18]) |=> !unpredictable);

  p_quad_misalign_r5: assert property (@(posedge clk) disable iff (rst)
    (instrWord[25:21] == 5'b01010 && instrWord[19:18] == 2'b00) |=> !unpredictable);

endmodule

// File: tb/tb_fpcc_group_branch.sv
`timescale 1ns/1ps
module tb_fpcc_group_branch;

  localparam int AW = 40;

  logic          clk = 1'b0;
  logic          rst;
  logic          instrValid, fpuEnable;
  logic [31:0]   instrWord;
  logic [7:0]    condCodes;
  logic [AW-1:0] nextPc;
  logic          isBranch, taken, unpredictable, delaySlot, redirectValid;
  logic [AW-1:0] target, redirectTarget;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // expectations for the cycle being checked, and for the redirect stage
  logic          eBr, eTk, eUn;
  logic [AW-1:0] eTg;
  logic          pTk;
  logic [AW-1:0] pTg;

  always #10 clk = ~clk;

  fpcc_group_branch #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .instrValid(instrValid), .fpuEnable(fpuEnable),
    .instrWord(instrWord), .condCodes(condCodes), .nextPc(nextPc),
    .isBranch(isBranch), .taken(taken), .unpredictable(unpredictable),
    .target(target), .delaySlot(delaySlot), .redirectValid(redirectValid),
    .redirectTarget(redirectTarget)
  );

  function automatic logic [31:0] mkWord(logic quad, logic [2:0] cc, logic tf, logic [15:0] off);
    return {6'b010001, quad ? 5'b01010 : 5'b01001, cc, 1'b0, tf, off};
  endfunction

  // Model built from the requirements
  task automatic model();
    logic       hit, quad, mis, any;
    logic [2:0] cc;
    logic [AW-1:0] ext;
    quad = (instrWord[25:21] == 5'b01010);
    cc   = instrWord[20:18];
    hit  = instrValid && fpuEnable && instrWord[31:26] == 6'b010001 &&
           (instrWord[25:21] == 5'b01001 || quad) && !instrWord[17];
    mis  = hit && (quad ? (cc[1:0] != 0) : cc[0]);
    any  = 1'b0;
    for (int k = 0; k < (quad ? 4 : 2); k++)
      if (condCodes[3'(cc + 3'(k))] == instrWord[16]) any = 1'b1;
    ext  = AW'($signed(instrWord[15:0])) <<< 2;
    eBr  = hit;
    eUn  = mis;
    eTk  = hit && !mis && any;
    eTg  = hit ? nextPc + ext : '0;
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h word=%h cc=%b", req, act, exp, instrWord, condCodes);
    end
  endtask

  // Drive at negedge, check after the following posedge
  task automatic step();
    model();
    @(negedge clk);
    chk("R1 isBranch", 64'(isBranch), 64'(eBr));
    chk("R2 R3 R6 taken", 64'(taken), 64'(eTk));
    chk("R4 R5 unpredictable", 64'(unpredictable), 64'(eUn));
    chk("R8 target", 64'(target), 64'(eTg));
    chk("R9 delaySlot", 64'(delaySlot), 64'(eBr));
    chk("R10 redirectValid", 64'(redirectValid), 64'(pTk));
    chk("R10 redirectTarget", 64'(redirectTarget), 64'(pTk ? pTg : '0));
    pTk = eTk;
    pTg = eTg;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    rst = 1'b1; instrValid = 0; fpuEnable = 0; instrWord = '0; condCodes = '0; nextPc = '0;
    pTk = 0; pTg = '0;
    @(negedge clk); @(negedge clk);
    // R11: reset state
    chk("R11 reset isBranch", 64'(isBranch), 0);
    chk("R11 reset taken", 64'(taken), 0);
    chk("R11 reset target", 64'(target), 0);
    chk("R11 reset redirect", 64'(redirectValid), 0);
    rst = 1'b0;
    instrValid = 1; fpuEnable = 1;

    // R2: pair at cc=2, sense 1, only code 3 set -> taken
    instrWord = mkWord(0, 3'd2, 1, 16'h0010); condCodes = 8'b0000_1000; nextPc = 40'h00_1000_0000;
    step();
    // R2: pair, sense 1, neither set -> not taken
    instrWord = mkWord(0, 3'd2, 1, 16'h0010); condCodes = 8'b1111_0011;
    step();
    // R3: quad at cc=4, sense 0, only code 7 clear; negative offset (R8)
    instrWord = mkWord(1, 3'd4, 0, 16'hFFFE); condCodes = 8'b0111_1111; nextPc = 40'h00_0000_0004;
    step();
    // R3: quad, sense 0, all set -> not taken
    instrWord = mkWord(1, 3'd4, 0, 16'h8000); condCodes = 8'hFF;
    step();
    // R4: pair odd index, would match -> unpredictable, not taken (R6)
    instrWord = mkWord(0, 3'd5, 1, 16'h0001); condCodes = 8'hFF;
    step();
    // R5: quad index 6 -> unpredictable
    instrWord = mkWord(1, 3'd6, 1, 16'h0001); condCodes = 8'hFF;
    step();
    // R8: wrap at 2^40
    instrWord = mkWord(0, 3'd0, 1, 16'h7FFF); condCodes = 8'h01; nextPc = 40'hFF_FFFF_FFF0;
    step();
    // R7: strobe low / enable low with matching word
    instrValid = 0; step();
    instrValid = 1; fpuEnable = 0; step();
    fpuEnable = 1;
    // R1: pad bit set rejects
    instrWord = mkWord(0, 3'd0, 1, 16'h0004) | 32'h0002_0000; step();
    // R11: reset mid-stream after a taken branch clears redirect
    instrWord = mkWord(0, 3'd0, 1, 16'h0004); condCodes = 8'h01; step();
    rst = 1'b1; @(negedge clk);
    chk("R11 reset redirect", 64'(redirectValid), 0);
    chk("R11 reset taken", 64'(taken), 0);
    rst = 1'b0; pTk = 0; pTg = '0;

    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom % 8;
      instrWord  = $urandom;
      if (r != 0) instrWord[31:26] = 6'b010001;
      if (r < 4) instrWord[25:21] = 5'b01001;
      else if (r < 7) instrWord[25:21] = 5'b01010;
      if ($urandom % 8 != 0) instrWord[17] = 1'b0;
      condCodes  = 8'($urandom);
      nextPc     = {8'($urandom), 32'($urandom)};
      instrValid = ($urandom % 10) != 0;
      fpuEnable  = ($urandom % 10) != 0;
      step();
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule